// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register with Serial Mode

This block is a register of `WIDTH` stages (eight by default) placed between two parallel buses, called A and B. It can copy a word from either bus into its stages and present it on the other bus. It can also collect a serial bit stream into parallel form, or hold its contents by having every stage reload its own value. A word loaded from a bus can be shifted out of the last stage, which makes the block usable as a parallel-to-serial converter and lets several blocks be chained.

Each bus is modelled as three signals: an input word, an output word and an output enable. The output word always carries the stage contents. The enable says whether that side is currently driving. A slow register clock `reg_clk` is sampled on the fast system clock `clk`. Its rising edges drive synchronous loads and every serial shift. In parallel mode, asynchronous selection makes the load level-sensitive, so the stages follow the source on every system clock cycle.

Top module: `bus_xfer_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every stage to zero and drives `a_oe` and `b_oe` low in the next cycle.
- R2: With `par_mode`=1, `async_sel`=0, `a_to_b`=1 and `a_en`=1, the stages take `a_in` only in the system cycle in which a rising edge of `reg_clk` is seen, which is a cycle where `reg_clk` is 1 and was 0 at the previous system edge. In every other cycle they hold.
- R3: With `par_mode`=1 and `async_sel`=1, the stages take the selected parallel source on every system clock edge, whether or not `reg_clk` changes.
- R4: With `par_mode`=1 and `a_to_b`=0, the source is `b_in`, and `a_in` has no effect whatever the value of `a_en`.
- R5: With `par_mode`=1, `a_to_b`=1 and `a_en`=0, every stage keeps its value in both synchronous and asynchronous selection, and `a_in` has no effect.
- R6: With `par_mode`=0, each rising edge of `reg_clk` moves stage i to stage i+1 and loads `ser_in` into stage 0 (bit 0). `async_sel` is ignored, and no shift happens without an edge.
- R7: `ser_out` equals stage `WIDTH-1` (the most significant bit).
- R8: One cycle after any control change, `b_oe` equals the previous `a_to_b`, and `a_oe` equals the previous `a_en AND NOT a_to_b`. The two are never high together.
- R9: `a_out` and `b_out` both carry the stage contents, with stage i on bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_clk | input | 1 | Register clock, acted on at its rising edge |
| par_mode | input | 1 | 1 = parallel load, 0 = serial shift |
| async_sel | input | 1 | 1 = level-sensitive parallel load, 0 = edge-timed |
| a_to_b | input | 1 | 1 = A is source and B is driven, 0 = the reverse |
| a_en | input | 1 | Gate for the A side, both input and output |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | WIDTH | Word read from bus A |
| b_in | input | WIDTH | Word read from bus B |
| a_out | output | WIDTH | Stage contents toward bus A |
| a_oe | output | 1 | A side drive enable |
| b_out | output | WIDTH | Stage contents toward bus B |
| b_oe | output | 1 | B side drive enable |
| ser_out | output | 1 | Last stage, for chaining |

## Verification
The bench first applies a steady A word and withholds the register clock. This separates edge-timed loading from level loading. It then changes the A word on every cycle under asynchronous selection, which shows whether the stages track the source or only latch it once. With the direction reversed, it drives conflicting words on A and B to prove that the right source is picked. With A disabled, it drives A and pulses the clock to expose any leak into the recirculating stages. A non-repeating serial pattern, shifted more than `WIDTH` times with `async_sel` set, exposes errors in shift direction, entry point and last-stage output.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } xfer_op_e;

  typedef enum logic [1:0] {
    SRC_SELF = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } xfer_src_e;
endpackage

// File: rtl/xfer_edge_det.sv
module xfer_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import bus_xfer_pkg::*;
(
  input  logic      par_mode,
  input  logic      async_sel,
  input  logic      a_to_b,
  input  logic      a_en,
  input  logic      rise,
  output xfer_op_e  op,
  output xfer_src_e src
);
  always_comb begin
    if (!par_mode)               op = rise ? OP_SHIFT : OP_HOLD;
    else if (async_sel || rise)  op = OP_LOAD;
    else                         op = OP_HOLD;
  end

  always_comb begin
    if (!a_to_b)   src = SRC_B;
    else if (a_en) src = SRC_A;
    else           src = SRC_SELF;
  end
endmodule

// File: rtl/xfer_stages.sv
module xfer_stages
  import bus_xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xfer_op_e         op,
  input  logic [WIDTH-1:0] par_data,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shift_src;
    if (i == 0) begin : g_first
      assign shift_src = ser_in;
    end else begin : g_rest
      assign shift_src = q[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else begin
        case (op)
          OP_SHIFT: q[i] <= shift_src;
          OP_LOAD:  q[i] <= par_data[i];
          default:  q[i] <= q[i];
        endcase
      end
    end
  end

  // R6: a shift moves every stage up by one and enters ser_in at bit 0
  a_r6_shift_order: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

  // R1: reset clears all stages
  a_r1_stage_clear: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
  import bus_xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_clk,
  input  logic             par_mode,
  input  logic             async_sel,
  input  logic             a_to_b,
  input  logic             a_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             ser_out
);
  localparam int MSB = WIDTH - 1;

  logic             rise;
  xfer_op_e         op;
  xfer_src_e        src;
  logic [WIDTH-1:0] par_data;
  logic [WIDTH-1:0] q;

  xfer_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (reg_clk),
    .rise     (rise)
  );

  xfer_ctrl u_ctrl (
    .par_mode  (par_mode),
    .async_sel (async_sel),
    .a_to_b    (a_to_b),
    .a_en      (a_en),
    .rise      (rise),
    .op        (op),
    .src       (src)
  );

  always_comb begin
    case (src)
      SRC_A:   par_data = a_in;
      SRC_B:   par_data = b_in;
      default: par_data = q;
    endcase
  end

  xfer_stages #(.WIDTH(WIDTH)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .par_data (par_data),
    .ser_in   (ser_in),
    .q        (q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else begin
      a_oe <= a_en & ~a_to_b;
      b_oe <= a_to_b;
    end
  end

  assign a_out   = q;
  assign b_out   = q;
  assign ser_out = q[MSB];

  // R8: the two sides never drive at the same time
  a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  // R1: enables are off after reset
  a_r1_oe_off: assert property (@(posedge clk) rst |=> (!a_oe && !b_oe));

  // R5: recirculation keeps the stages unchanged
  a_r5_recirc_hold: assert property (@(posedge clk) disable iff (rst)
    (par_mode && a_to_b && !a_en) |=> $stable(q));

  // R2: edge-timed parallel mode does nothing without a register clock edge
  a_r2_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (par_mode && !async_sel && !rise) |=> $stable(q));

  // R6: serial mode without an edge holds
  a_r6_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && !rise) |=> $stable(q));
endmodule

// File: tb/bus_xfer_reg_tb_top.sv
module bus_xfer_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_clk = 1'b0;
  logic         par_mode = 1'b0;
  logic         async_sel = 1'b0;
  logic         a_to_b = 1'b0;
  logic         a_en = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, ser_out;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";

  always #4 clk = ~clk;

  bus_xfer_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .reg_clk(reg_clk), .par_mode(par_mode),
    .async_sel(async_sel), .a_to_b(a_to_b), .a_en(a_en), .ser_in(ser_in),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out),
    .b_oe(b_oe), .ser_out(ser_out)
  );

  // Behavioural reference: bit queue, index 0 = stage 0
  bit m_bits[$];
  bit m_prev;
  bit m_aoe, m_boe;

  function automatic logic [W-1:0] m_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = m_bits[i];
    return w;
  endfunction

  initial begin
    for (int i = 0; i < W; i++) m_bits.push_back(1'b0);
  end

  always @(posedge clk) begin
    bit edge_seen;
    if (rst) begin
      for (int i = 0; i < W; i++) m_bits[i] = 1'b0;
      m_prev = 1'b0; m_aoe = 1'b0; m_boe = 1'b0;
    end else begin
      edge_seen = reg_clk && !m_prev;
      m_prev = reg_clk;
      if (!par_mode) begin
        if (edge_seen) begin
          m_bits.push_front(ser_in);
          void'(m_bits.pop_back());
        end
      end else if (async_sel || edge_seen) begin
        if (!a_to_b)
          for (int i = 0; i < W; i++) m_bits[i] = b_in[i];
        else if (a_en)
          for (int i = 0; i < W; i++) m_bits[i] = a_in[i];
      end
      m_aoe = a_en && !a_to_b;
      m_boe = a_to_b;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, a_out, m_word(), "stages on a_out");
      check("R9", b_out, a_out, "b_out vs a_out");
      check("R7", {7'd0, ser_out}, {7'd0, m_bits[W-1]}, "ser_out");
      check("R8", {6'd0, a_oe, b_oe}, {6'd0, m_aoe, m_boe}, "enables");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) reg_clk = 1'b1;
    idle(2);
    reg_clk = 1'b0;
    idle(2);
  endtask

  localparam logic [15:0] SER_PAT = 16'b1011_0010_0111_1000;

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", a_out, '0, "stages after reset");
    check("R1", {6'd0, a_oe, b_oe}, 8'd0, "enables after reset");

    // R2: edge-timed load from A
    cur_req = "R2";
    par_mode = 1; async_sel = 0; a_to_b = 1; a_en = 1; a_in = 8'hA5;
    idle(5);
    check("R2", a_out, 8'h00, "no load without edge");
    pulse();
    check("R2", a_out, 8'hA5, "load on edge");
    a_in = 8'h0F; idle(4);
    check("R2", a_out, 8'hA5, "holds between edges");

    // R3: level load follows A each cycle
    cur_req = "R3";
    async_sel = 1; a_in = 8'h3C; idle(2);
    check("R3", a_out, 8'h3C, "level load");
    a_in = 8'h81; idle(1); a_in = 8'h7E; idle(2);
    check("R3", a_out, 8'h7E, "tracks source");

    // R4: B is source, A ignored
    cur_req = "R4";
    a_to_b = 0; async_sel = 0; a_in = 8'hFF; b_in = 8'h5A;
    pulse();
    check("R4", a_out, 8'h5A, "edge load from B");
    a_en = 0; async_sel = 1; b_in = 8'hC3; idle(3);
    check("R4", a_out, 8'hC3, "level load from B, A off");

    // R5: recirculation
    cur_req = "R5";
    a_to_b = 1; a_en = 0; async_sel = 0; a_in = 8'h11;
    pulse(); pulse();
    check("R5", a_out, 8'hC3, "sync recirculation");
    async_sel = 1; a_in = 8'h22; idle(4);
    check("R5", a_out, 8'hC3, "async recirculation");

    // R6: serial shift, async_sel ignored
    cur_req = "R6";
    par_mode = 0; async_sel = 1; a_to_b = 0; a_en = 1;
    idle(3);
    check("R6", a_out, 8'hC3, "no shift without edge");
    for (int i = 0; i < 12; i++) begin
      ser_in = SER_PAT[i];
      pulse();
    end
    check("R6", a_out, {SER_PAT[4], SER_PAT[5], SER_PAT[6], SER_PAT[7],
                        SER_PAT[8], SER_PAT[9], SER_PAT[10], SER_PAT[11]}, "serial word");
    check("R7", {7'd0, ser_out}, {7'd0, SER_PAT[4]}, "last stage out");
    a_to_b = 1; idle(2);
    check("R8", {6'd0, a_oe, b_oe}, 8'd1, "serial with B driven");

    // R1: reset again from non-zero state
    cur_req = "R1";
    rst = 1; idle(2); rst = 0; @(negedge clk);
    check("R1", a_out, '0, "second reset clears");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule